// File: doc/BRIEF.md
# 1-Wire ROM Search Engine

This block walks the binary identifier tree of a 1-Wire bus and returns one 64-bit device identifier each time it is started. It sits above a bit-level slot engine. It asks that engine for a bus reset, single write slots and single read slots, and it waits for a done strobe after each request.

Between runs the block keeps two things: the identifier it found last, and the position of the last branch where it took the zero side. Each new run uses them to follow the next unexplored branch. Repeated starts therefore list every device on the bus, in order. When no untried branch is left, the block raises a finished flag. After that, further starts report that no identifier was found, until a clear command wipes the stored history.

A run that loses all responding devices part-way through stops at once. It leaves no slot request outstanding, so normal byte traffic on the slot engine can continue.

Top module: `ows_engine`

## Requirements
- R1: A start while finished is low first issues a bus reset request (op code 2'b01). If the done strobe reports no presence, the block pulses `none_o` for one cycle, sets `finished_o`, and makes no further request.
- R2: After a reset that reports presence, the block issues eight write slots (op 2'b10) carrying 0xF0, least-significant bit first.
- R3: For each of the 64 identifier positions, the block issues exactly two read slots (op 2'b11) and then one write slot. It never has more than one request outstanding. A full run issues 1 + 8 + 192 requests.
- R4: A read pair (bit, complement) of 0,1 writes 0. A pair of 1,0 writes 1.
- R5: A read pair of 1,1 ends the run without a write slot. The block pulses `none_o`, sets `finished_o`, returns to idle and issues no further request.
- R6: A pair of 0,0 is resolved by its position p (1 to 64) against the stored last discrepancy L. For p < L the block writes bit p-1 of the stored identifier; for p = L it writes 1; for p > L it writes 0. As a result, repeated runs return the devices in ascending order of their bit-reversed identifiers.
- R7: Bit i of `id_o` is the bit written at position i+1. The first bit written is the least-significant bit of the identifier.
- R8: A completed run pulses `id_valid_o` for one cycle with `id_o` holding the identifier. It stores the last 0,0 position where 0 was written as the new last discrepancy, and sets `finished_o` exactly when no such position exists.
- R9: A start while `finished_o` is high pulses `none_o` in the next cycle and issues no request.
- R10: A clear while idle sets the stored identifier, the last discrepancy and `finished_o` to zero, so the next start enumerates from the first device again. Clear takes priority over a start in the same cycle.
- R11: After reset the block is idle, with `busy_o`, `req_o`, `id_valid_o`, `none_o` and `finished_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start one search run (sampled while idle) |
| clear_i | input | 1 | Clear the stored search history (sampled while idle) |
| req_o | output | 1 | One-cycle request to the slot engine |
| op_o | output | 2 | Request kind: 01 bus reset, 10 write slot, 11 read slot |
| wbit_o | output | 1 | Bit to send in a write slot |
| done_i | input | 1 | Slot engine finished the outstanding request |
| rbit_i | input | 1 | Bus level sampled in a read slot, valid with done_i |
| presence_i | input | 1 | Presence seen after a bus reset, valid with done_i |
| id_o | output | 64 | Identifier found by the last completed run |
| id_valid_o | output | 1 | One-cycle strobe: id_o holds a new identifier |
| none_o | output | 1 | One-cycle strobe: the run returned no identifier |
| finished_o | output | 1 | Every device has been listed, or the bus stopped responding |
| busy_o | output | 1 | A run is in progress |

## Verification
The bench drives the engine against a wired-AND bus model that holds zero to four identifiers. It uses four kinds of device population. A single device exercises only the conflict-free pair decoding and the bit order of the result. Three devices with differing low bits force repeated 0,0 branches, and the returned order shows whether the stored discrepancy and the previous identifier steer each branch correctly. Two devices that differ only in the top bit place the sole discrepancy at position 64. An empty bus, and a bus whose devices vanish mid-run, separate the no-presence path from the 1,1 abort path, and both show that no request stays pending afterwards.

// File: rtl/ows_pkg.sv
package ows_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_RESET = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } slot_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSRST,
        ST_CMD,
        ST_RD_BIT,
        ST_RD_CMP,
        ST_WR
    } srch_state_e;

    typedef struct packed {
        logic abort;
        logic bit_val;
        logic zero_pick;
    } branch_t;

endpackage

// File: rtl/ows_decide.sv
module ows_decide
    import ows_pkg::*;
#(
    parameter int ID_W = 64,
    localparam int PW = $clog2(ID_W),
    localparam int DW = $clog2(ID_W + 1)
) (
    input  logic          rd_bit,
    input  logic          rd_cmp,
    input  logic [PW-1:0] pos,
    input  logic [DW-1:0] last_disc,
    input  logic          prev_bit,
    output branch_t       br
);
    logic [DW-1:0] pos1;
    assign pos1 = DW'(pos) + DW'(1);

    always_comb begin
        br = '0;
        unique case ({rd_bit, rd_cmp})
            2'b01: br.bit_val = 1'b0;
            2'b10: br.bit_val = 1'b1;
            2'b11: br.abort   = 1'b1;
            default: begin
                if (pos1 < last_disc)       br.bit_val = prev_bit;
                else if (pos1 == last_disc) br.bit_val = 1'b1;
                else                        br.bit_val = 1'b0;
                br.zero_pick = !br.bit_val;
            end
        endcase
    end
endmodule

// File: rtl/ows_history.sv
module ows_history #(
    parameter int ID_W = 64,
    localparam int DW = $clog2(ID_W + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear_i,
    input  logic            commit_i,
    input  logic [ID_W-1:0] commit_id,
    input  logic [DW-1:0]   commit_disc,
    input  logic            fail_i,
    output logic [ID_W-1:0] last_id,
    output logic [DW-1:0]   last_disc,
    output logic            finished
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            last_id   <= '0;
            last_disc <= '0;
            finished  <= 1'b0;
        end else if (commit_i) begin
            last_id   <= commit_id;
            last_disc <= commit_disc;
            finished  <= (commit_disc == '0);
        end else if (fail_i) begin
            finished  <= 1'b1;
        end
    end

    // R10: a clear leaves no history behind
    assert_clear_wipes_R10: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (!finished && last_disc == '0 && last_id == '0));

    // R8: finished follows the committed discrepancy
    assert_commit_finish_R8: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !clear_i) |=> (finished == (last_disc == '0)));
endmodule

// File: rtl/ows_engine.sv
module ows_engine
    import ows_pkg::*;
#(
    parameter int        ID_W     = 64,
    parameter int        CMD_W    = 8,
    parameter logic [7:0] CMD_BYTE = 8'hF0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            clear_i,
    output logic            req_o,
    output logic [1:0]      op_o,
    output logic            wbit_o,
    input  logic            done_i,
    input  logic            rbit_i,
    input  logic            presence_i,
    output logic [ID_W-1:0] id_o,
    output logic            id_valid_o,
    output logic            none_o,
    output logic            finished_o,
    output logic            busy_o
);
    localparam int PW = $clog2(ID_W);
    localparam int DW = $clog2(ID_W + 1);
    localparam int CW = $clog2(CMD_W);

    srch_state_e     state_q;
    logic            pend_q;
    logic [PW-1:0]   pos_q;
    logic [CW-1:0]   cidx_q;
    logic            rd0_q, rd1_q;
    logic [ID_W-1:0] acc_q;
    logic [DW-1:0]   zero_q;
    logic            id_valid_q, none_q;

    logic [ID_W-1:0] last_id;
    logic [DW-1:0]   last_disc;
    logic            finished;
    branch_t         br;

    logic            idle_clear, idle_start;
    logic            fail, commit, wr_done, last_pos;
    logic [ID_W-1:0] next_acc;
    logic [DW-1:0]   next_zero;

    ows_decide #(.ID_W(ID_W)) u_decide (
        .rd_bit    (rd0_q),
        .rd_cmp    (rd1_q),
        .pos       (pos_q),
        .last_disc (last_disc),
        .prev_bit  (last_id[pos_q]),
        .br        (br)
    );

    assign idle_clear = (state_q == ST_IDLE) && clear_i;
    assign idle_start = (state_q == ST_IDLE) && start_i && !clear_i;
    assign wr_done    = (state_q == ST_WR) && !br.abort && done_i;
    assign last_pos   = (pos_q == PW'(ID_W - 1));
    assign next_acc   = {br.bit_val, acc_q[ID_W-1:1]};
    assign next_zero  = br.zero_pick ? DW'(pos_q) + DW'(1) : zero_q;
    assign commit     = wr_done && last_pos;
    assign fail       = ((state_q == ST_BUSRST) && done_i && !presence_i)
                      || ((state_q == ST_WR) && br.abort);

    ows_history #(.ID_W(ID_W)) u_hist (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (idle_clear),
        .commit_i    (commit),
        .commit_id   (next_acc),
        .commit_disc (next_zero),
        .fail_i      (fail),
        .last_id     (last_id),
        .last_disc   (last_disc),
        .finished    (finished)
    );

    always_comb begin
        req_o  = (state_q != ST_IDLE) && !pend_q
               && !((state_q == ST_WR) && br.abort);
        op_o   = OP_NONE;
        wbit_o = 1'b0;
        unique case (state_q)
            ST_BUSRST:           op_o = OP_RESET;
            ST_CMD: begin
                op_o   = OP_WRITE;
                wbit_o = CMD_BYTE[cidx_q];
            end
            ST_RD_BIT, ST_RD_CMP: op_o = OP_READ;
            ST_WR: begin
                op_o   = OP_WRITE;
                wbit_o = br.bit_val;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pend_q     <= 1'b0;
            pos_q      <= '0;
            cidx_q     <= '0;
            rd0_q      <= 1'b0;
            rd1_q      <= 1'b0;
            acc_q      <= '0;
            zero_q     <= '0;
            id_valid_q <= 1'b0;
            none_q     <= 1'b0;
        end else begin
            id_valid_q <= 1'b0;
            none_q     <= 1'b0;
            if (req_o) pend_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (idle_start) begin
                        if (finished) begin
                            none_q <= 1'b1;
                        end else begin
                            state_q <= ST_BUSRST;
                            pos_q   <= '0;
                            cidx_q  <= '0;
                            zero_q  <= '0;
                            acc_q   <= '0;
                        end
                    end
                end
                ST_BUSRST: if (done_i) begin
                    pend_q <= 1'b0;
                    if (presence_i) begin
                        state_q <= ST_CMD;
                    end else begin
                        state_q <= ST_IDLE;
                        none_q  <= 1'b1;
                    end
                end
                ST_CMD: if (done_i) begin
                    pend_q <= 1'b0;
                    cidx_q <= cidx_q + CW'(1);
                    if (cidx_q == CW'(CMD_W - 1)) state_q <= ST_RD_BIT;
                end
                ST_RD_BIT: if (done_i) begin
                    pend_q  <= 1'b0;
                    rd0_q   <= rbit_i;
                    state_q <= ST_RD_CMP;
                end
                ST_RD_CMP: if (done_i) begin
                    pend_q  <= 1'b0;
                    rd1_q   <= rbit_i;
                    state_q <= ST_WR;
                end
                ST_WR: begin
                    if (br.abort) begin
                        state_q <= ST_IDLE;
                        none_q  <= 1'b1;
                    end else if (done_i) begin
                        pend_q <= 1'b0;
                        acc_q  <= next_acc;
                        zero_q <= next_zero;
                        if (last_pos) begin
                            state_q    <= ST_IDLE;
                            id_valid_q <= 1'b1;
                        end else begin
                            pos_q   <= pos_q + PW'(1);
                            state_q <= ST_RD_BIT;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign id_o       = acc_q;
    assign id_valid_o = id_valid_q;
    assign none_o     = none_q;
    assign finished_o = finished;
    assign busy_o     = (state_q != ST_IDLE);

    // R1: every run opens with a bus reset request
    assert_first_op_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (req_o && op_o == OP_RESET));

    // R3: a request is never issued while another is outstanding
    assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

    // R3: the slot engine only completes what was asked for
    assert_done_only_pending_R3: assert property (@(posedge clk) disable iff (rst)
        done_i |-> pend_q);

    // R5: a run without result leaves the engine idle and finished
    assert_none_idle_R5: assert property (@(posedge clk) disable iff (rst)
        none_o |-> (finished_o && !pend_q && !busy_o));

    // R8: result and no-result strobes never coincide
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(id_valid_o && none_o));
endmodule

// File: tb/ows_engine_tb_top.sv
module ows_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        clear_i = 1'b0;
    logic        req_o;
    logic [1:0]  op_o;
    logic        wbit_o;
    logic        done_i = 1'b0;
    logic        rbit_i = 1'b0;
    logic        presence_i = 1'b0;
    logic [63:0] id_o;
    logic        id_valid_o, none_o, finished_o, busy_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ows_engine dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .clear_i(clear_i),
        .req_o(req_o), .op_o(op_o), .wbit_o(wbit_o), .done_i(done_i),
        .rbit_i(rbit_i), .presence_i(presence_i), .id_o(id_o),
        .id_valid_o(id_valid_o), .none_o(none_o), .finished_o(finished_o),
        .busy_o(busy_o)
    );

    // ---------------- wired-AND bus model ----------------
    logic [63:0] dev_id [4];
    int          n_dev = 0;
    int          vanish_at = 1000;
    logic [3:0]  act = '0;
    int          wcnt = 0, pos_m = 0, phase = 0, cnt = 0;
    logic [7:0]  cmd_cap = '0;
    int          ops_seen = 0, proto_err = 0;

    always @(posedge clk) begin
        done_i <= 1'b0;
        if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) done_i <= 1'b1;
        end
        if (req_o) begin
            logic rb;
            ops_seen = ops_seen + 1;
            if (cnt != 0) proto_err = proto_err + 1;
            cnt = 3;
            case (op_o)
                2'b01: begin
                    act = '0;
                    for (int d = 0; d < 4; d++) if (d < n_dev) act[d] = 1'b1;
                    presence_i <= (n_dev > 0);
                    wcnt = 0; pos_m = 0; phase = 0;
                end
                2'b10: begin
                    if (wcnt < 8) cmd_cap[wcnt] = wbit_o;
                    else begin
                        if (phase != 2) proto_err = proto_err + 1;
                        for (int d = 0; d < 4; d++)
                            if (dev_id[d][pos_m] != wbit_o) act[d] = 1'b0;
                        pos_m = pos_m + 1;
                        phase = 0;
                    end
                    wcnt = wcnt + 1;
                end
                2'b11: begin
                    if (wcnt < 8 || phase > 1) proto_err = proto_err + 1;
                    rb = 1'b1;
                    for (int d = 0; d < 4; d++)
                        if (act[d] && ((phase == 0) ? !dev_id[d][pos_m] : dev_id[d][pos_m]))
                            rb = 1'b0;
                    if (pos_m >= vanish_at) rb = 1'b1;
                    rbit_i <= rb;
                    phase = phase + 1;
                end
                default: proto_err = proto_err + 1;
            endcase
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act_v, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act_v, exp_v);
        end
    endtask

    task automatic run_search(output logic got_id, output logic got_none,
                              output logic [63:0] id);
        got_id = 1'b0; got_none = 1'b0; id = '0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (id_valid_o) begin got_id = 1'b1; id = id_o; break; end
            if (none_o) begin got_none = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic do_clear();
        @(negedge clk) clear_i = 1'b1;
        @(negedge clk) clear_i = 1'b0;
    endtask

    function automatic logic [63:0] brev(input logic [63:0] x);
        for (int i = 0; i < 64; i++) brev[i] = x[63-i];
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        chk(!busy_o && !req_o && !id_valid_o && !none_o && !finished_o, "R11",
            "idle after reset", {busy_o, req_o, id_valid_o, none_o, finished_o}, 0);
    endtask

    task automatic t_empty_bus();
        logic gi, gn; logic [63:0] id;
        int ops0;
        n_dev = 0; ops0 = ops_seen;
        run_search(gi, gn, id);
        chk(gn && !gi, "R1", "empty bus gives none", {gi, gn}, 1);
        chk(finished_o, "R1", "finished after no presence", finished_o, 1);
        repeat (10) @(negedge clk);
        chk(ops_seen - ops0 == 1 && !busy_o, "R1", "only one reset request",
            ops_seen - ops0, 1);
        do_clear();
        chk(!finished_o, "R10", "clear drops finished", finished_o, 0);
    endtask

    task automatic t_single();
        logic gi, gn; logic [63:0] id;
        int ops0;
        n_dev = 1; dev_id[0] = 64'h8C00_1234_5678_9AB1; ops0 = ops_seen; proto_err = 0;
        run_search(gi, gn, id);
        chk(gi && id == dev_id[0], "R4", "single device identifier", id, dev_id[0]);
        chk(id[0] == 1'b1 && id[63] == 1'b1, "R7", "bit order of result", id, dev_id[0]);
        chk(cmd_cap == 8'hF0, "R2", "command byte", cmd_cap, 8'hF0);
        chk(ops_seen - ops0 == 201 && proto_err == 0, "R3", "request sequence",
            ops_seen - ops0, 201);
        chk(finished_o, "R8", "single device ends search", finished_o, 1);
    endtask

    task automatic t_start_when_done();
        logic gi, gn; logic [63:0] id;
        int ops0;
        ops0 = ops_seen;
        run_search(gi, gn, id);
        chk(gn && !gi, "R9", "start while finished gives none", {gi, gn}, 1);
        repeat (10) @(negedge clk);
        chk(ops_seen == ops0, "R9", "no bus activity", ops_seen - ops0, 0);
    endtask

    task automatic t_enumerate(input int n);
        logic gi, gn; logic [63:0] id, exp_id;
        logic [3:0] seen;
        seen = '0; proto_err = 0;
        for (int k = 0; k < n; k++) begin
            int best;
            best = -1;
            for (int d = 0; d < n; d++)
                if (!seen[d] && (best < 0 || brev(dev_id[d]) < brev(dev_id[best]))) best = d;
            seen[best] = 1'b1;
            exp_id = dev_id[best];
            run_search(gi, gn, id);
            chk(gi && id == exp_id, "R6", "enumeration order", id, exp_id);
            chk(finished_o == (k == n - 1), "R8", "finished only after last",
                finished_o, (k == n - 1));
        end
        chk(proto_err == 0 && cmd_cap == 8'hF0, "R3", "slot protocol in enumeration",
            proto_err, 0);
    endtask

    task automatic t_abort();
        logic gi, gn; logic [63:0] id;
        int ops0;
        do_clear();
        n_dev = 2; dev_id[0] = 64'h0000_0000_0000_0F00; dev_id[1] = 64'h0000_0000_0000_0F01;
        vanish_at = 10;
        run_search(gi, gn, id);
        chk(gn && !gi, "R5", "vanishing bus aborts", {gi, gn}, 1);
        chk(finished_o, "R5", "abort sets finished", finished_o, 1);
        ops0 = ops_seen;
        repeat (20) @(negedge clk);
        chk(ops_seen == ops0 && !busy_o && cnt == 0, "R5", "no request after abort",
            ops_seen - ops0, 0);
        vanish_at = 1000;
        do_clear();
        run_search(gi, gn, id);
        chk(gi && id == dev_id[0], "R10", "restart after clear", id, dev_id[0]);
    endtask

    task automatic t_clear_priority();
        logic [63:0] dummy;
        dummy = '0;
        @(negedge clk) begin clear_i = 1'b1; start_i = 1'b1; end
        @(negedge clk) begin clear_i = 1'b0; start_i = 1'b0; end
        chk(!busy_o && !none_o && !finished_o, "R10", "clear wins over start",
            {busy_o, none_o, finished_o}, dummy);
    endtask

    // ---------------- main ----------------
    initial begin
        for (int d = 0; d < 4; d++) dev_id[d] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_empty_bus();
        t_single();
        t_start_when_done();
        do_clear();
        n_dev = 3;
        dev_id[0] = 64'hA5A5_0000_0000_0010;
        dev_id[1] = 64'h1234_0000_0000_0001;
        dev_id[2] = 64'hFFFF_0000_0000_0003;
        t_enumerate(3);
        t_start_when_done();
        do_clear();
        n_dev = 2;
        dev_id[0] = 64'h8000_0000_0000_0000;
        dev_id[1] = 64'h0000_0000_0000_0000;
        t_enumerate(2);
        t_abort();
        t_clear_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule